// File: doc/BRIEF.md
# Pin Function and Configuration Register Bank

This block holds the per-pin configuration for a group of general-purpose I/O pins and presents it to the pad ring. Each pin has four settings: a function-select code, a pull-resistor code, a drive-level code and an output data bit. All of them sit in 32-bit registers behind a simple read/write port. Software updates one pin by reading a register, masking and shifting that pin's field, and writing the word back. Pins are grouped into banks of equal size. A pin's flat index, used both in the register layout and on the pad vectors, is its bank number times the bank size plus its position inside the bank.

Function code 0 makes a pin an input and code 1 makes it a driven output. Codes 2 to 7 hand the pin to an alternate function outside this block. The pull code and the drive code are turned into pad controls. The drive code is a linear map of current: the code is the current in mA divided by 10, minus 1. The data register drives the output level. When it is read, each output pin returns the level last written to it, and every other pin returns its pad level after a two-stage synchronizer.

Top module: `pinbank_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset every function code is 0 (input), every pull code is 0, every drive code is 1 and every data bit is 0. So pin_oe and pin_out are all 0, and each 2-bit pin_drive field is 01.
- R2: With default parameters, the function codes sit in byte addresses 0x00, 0x04, 0x08 and 0x0C, eight pins per word. Pin p uses word p/8, bits 4*(p%8)+2 down to 4*(p%8). Bit 4*(p%8)+3 is not stored and reads as 0.
- R3: pin_func[3p+2:3p] equals the stored function code of pin p. pin_oe[p] is 1 exactly when that code is 1.
- R4: The pull codes sit at 0x1C (pins 0-15) and 0x20 (pins 16-31), in bits 2*(p%16)+1 down to 2*(p%16). Code 1 sets pin_pull_up. Code 2 sets pin_pull_dn. Codes 0 and 3 set neither, and code 3 still reads back as 3.
- R5: The drive codes sit at 0x14 (pins 0-15) and 0x18 (pins 16-31), in bits 2*(p%16)+1 down to 2*(p%16), and appear on pin_drive[2p+1:2p]. Codes 0, 1, 2 and 3 stand for 10, 20, 30 and 40 mA.
- R6: The data register sits at 0x10, with bit p for pin p. Writing it sets pin_out. Reading it returns the written bit for every pin whose function code is 1. pin_out changes only on a write to that register.
- R7: For a pin whose function code is not 1, the data bit reads back pad_in[p] through two flip-flops. A pad change made just after a clock edge is seen by a read whose enable is sampled at the third edge after the change, and not by earlier reads.
- R8: Word addresses from 9 up (byte 0x24 and above) are unused. Reads from them return 0, and writes to them change no register and no pad output.
- R9: bus_rdata is loaded at the clock edge where bus_rd_en is high and holds its value until the next read.
- R10: Pin index p = bank*PINS_PER_BANK + position. With the default 2 banks of 16 pins, bank 1 position 3 is pin 19: function word 0x08 slot 3, and pad vector bit 19.
- R11: Writing a register changes only the fields of the pins mapped to that register. Fields held in other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe; data is returned after the next edge |
| bus_addr | input | ADDR_W | Byte address; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held between reads |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pin_out | output | NUM_PINS | Output level to each pad |
| pin_oe | output | NUM_PINS | Output enable, high when the function code is 1 |
| pin_func | output | 3*NUM_PINS | Function-select code for each pin, for the pad mux |
| pin_pull_up | output | NUM_PINS | Pull-up enable |
| pin_pull_dn | output | NUM_PINS | Pull-down enable |
| pin_drive | output | 2*NUM_PINS | Drive-level code for each pin |

## Verification
The bench writes a function word with the unused fourth bit of every slot set. A design that stored that bit, or took the code from the wrong slot, would read back a value other than 0x76543210 and would give the pad mux the wrong codes. It sets pull code 3 and checks that it reads back while neither pull enable goes high; a decoder that treated 3 as a pull would switch on both resistors or one of them. It moves pad levels one cycle before a run of reads to pin the synchronizer depth at two stages, and mixes input and output pins in one data word so that a readback mux choosing by the wrong condition is caught. It also writes all ones to unused addresses and to bank 1, so that a decoder that folds or aliases addresses would corrupt fields that the per-clock comparison with the reference model watches.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int REG_W        = 32;
    localparam int FSEL_W       = 3;
    localparam int FSEL_SLOT    = 4;
    localparam int FSEL_PER_REG = REG_W / FSEL_SLOT;
    localparam int PULL_W       = 2;
    localparam int DRV_W        = 2;
    localparam int CFG_PER_REG  = REG_W / PULL_W;
    localparam int DATA_PER_REG = REG_W;

    typedef enum logic [FSEL_W-1:0] {
        FSEL_INPUT  = 3'd0,
        FSEL_OUTPUT = 3'd1,
        FSEL_ALT2   = 3'd2,
        FSEL_ALT3   = 3'd3,
        FSEL_ALT4   = 3'd4,
        FSEL_ALT5   = 3'd5,
        FSEL_ALT6   = 3'd6,
        FSEL_ALT7   = 3'd7
    } fsel_e;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_UP   = 2'd1,
        PULL_DOWN = 2'd2,
        PULL_RSVD = 2'd3
    } pull_e;

    typedef struct packed {
        fsel_e              fsel;
        pull_e              pull;
        logic [DRV_W-1:0]   drv;
        logic               dout;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RESET = '{
        fsel: FSEL_INPUT,
        pull: PULL_NONE,
        drv:  2'd1,
        dout: 1'b0
    };

    // Register map: function words, then data words, then drive, then pull.
    function automatic int fsel_words(input int n);
        return (n + FSEL_PER_REG - 1) / FSEL_PER_REG;
    endfunction

    function automatic int data_words(input int n);
        return (n + DATA_PER_REG - 1) / DATA_PER_REG;
    endfunction

    function automatic int cfg_words(input int n);
        return (n + CFG_PER_REG - 1) / CFG_PER_REG;
    endfunction

    function automatic int data_base(input int n);
        return fsel_words(n);
    endfunction

    function automatic int drv_base(input int n);
        return data_base(n) + data_words(n);
    endfunction

    function automatic int pull_base(input int n);
        return drv_base(n) + cfg_words(n);
    endfunction

    function automatic int total_words(input int n);
        return pull_base(n) + cfg_words(n);
    endfunction

    function automatic logic pull_is_up(input pull_e code);
        return code == PULL_UP;
    endfunction

    function automatic logic pull_is_down(input pull_e code);
        return code == PULL_DOWN;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_field_regs.sv
module pinbank_field_regs
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int WORD_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [WORD_W-1:0]       wr_word,
    input  logic [REG_W-1:0]        wr_data,
    output pin_cfg_t [NUM_PINS-1:0] cfg
);

    localparam int DATA_BASE = data_base(NUM_PINS);
    localparam int DRV_BASE  = drv_base(NUM_PINS);
    localparam int PULL_BASE = pull_base(NUM_PINS);

    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    pin_cfg_t [NUM_PINS-1:0] cfg_d;

    // Each pin's fields are looked for in their own register only, so a
    // write to one word leaves every field held elsewhere untouched.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_word == WORD_W'(p / FSEL_PER_REG)) begin
                    cfg_d[p].fsel = fsel_e'(wr_data[(p % FSEL_PER_REG) * FSEL_SLOT +: FSEL_W]);
                end
                if (wr_word == WORD_W'(DATA_BASE + p / DATA_PER_REG)) begin
                    cfg_d[p].dout = wr_data[p % DATA_PER_REG];
                end
                if (wr_word == WORD_W'(DRV_BASE + p / CFG_PER_REG)) begin
                    cfg_d[p].drv = wr_data[(p % CFG_PER_REG) * DRV_W +: DRV_W];
                end
                if (wr_word == WORD_W'(PULL_BASE + p / CFG_PER_REG)) begin
                    cfg_d[p].pull = pull_e'(wr_data[(p % CFG_PER_REG) * PULL_W +: PULL_W]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= {NUM_PINS{PIN_CFG_RESET}};
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pinbank_readback.sv
module pinbank_readback
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int WORD_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [WORD_W-1:0]       rd_word,
    input  pin_cfg_t [NUM_PINS-1:0] cfg,
    input  logic [NUM_PINS-1:0]     pad_sync,
    output logic [REG_W-1:0]        rdata
);

    localparam int DATA_BASE = data_base(NUM_PINS);
    localparam int DRV_BASE  = drv_base(NUM_PINS);
    localparam int PULL_BASE = pull_base(NUM_PINS);

    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;

    // Words that no pin claims fall through as zero.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_word == WORD_W'(p / FSEL_PER_REG)) begin
                rd_mux[(p % FSEL_PER_REG) * FSEL_SLOT +: FSEL_W] = cfg[p].fsel;
            end
            if (rd_word == WORD_W'(DATA_BASE + p / DATA_PER_REG)) begin
                rd_mux[p % DATA_PER_REG] = (cfg[p].fsel == FSEL_OUTPUT) ? cfg[p].dout
                                                                        : pad_sync[p];
            end
            if (rd_word == WORD_W'(DRV_BASE + p / CFG_PER_REG)) begin
                rd_mux[(p % CFG_PER_REG) * DRV_W +: DRV_W] = cfg[p].drv;
            end
            if (rd_word == WORD_W'(PULL_BASE + p / CFG_PER_REG)) begin
                rd_mux[(p % CFG_PER_REG) * PULL_W +: PULL_W] = cfg[p].pull;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pinbank_pad_drive.sv
module pinbank_pad_drive
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS     = 2,
    parameter int PINS_PER_BANK = 16,
    localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK
) (
    input  pin_cfg_t [NUM_PINS-1:0]      cfg,
    output logic [NUM_PINS-1:0]          pin_out,
    output logic [NUM_PINS-1:0]          pin_oe,
    output logic [NUM_PINS*FSEL_W-1:0]   pin_func,
    output logic [NUM_PINS-1:0]          pin_pull_up,
    output logic [NUM_PINS-1:0]          pin_pull_dn,
    output logic [NUM_PINS*DRV_W-1:0]    pin_drive
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
            localparam int P = b * PINS_PER_BANK + i;
            assign pin_func[P*FSEL_W +: FSEL_W] = cfg[P].fsel;
            assign pin_oe[P]                    = (cfg[P].fsel == FSEL_OUTPUT);
            assign pin_out[P]                   = cfg[P].dout;
            assign pin_pull_up[P]               = pull_is_up(cfg[P].pull);
            assign pin_pull_dn[P]               = pull_is_down(cfg[P].pull);
            assign pin_drive[P*DRV_W +: DRV_W]  = cfg[P].drv;
        end
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS     = 2,
    parameter int PINS_PER_BANK = 16,
    parameter int ADDR_W        = 8,
    localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr_en,
    input  logic                        bus_rd_en,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]         pad_in,
    output logic [NUM_PINS-1:0]         pin_out,
    output logic [NUM_PINS-1:0]         pin_oe,
    output logic [NUM_PINS*FSEL_W-1:0]  pin_func,
    output logic [NUM_PINS-1:0]         pin_pull_up,
    output logic [NUM_PINS-1:0]         pin_pull_dn,
    output logic [NUM_PINS*DRV_W-1:0]   pin_drive
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]       word_idx;
    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     pad_sync;

    assign word_idx = WORD_W'(bus_addr >> 2);

    pinbank_field_regs #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .wr_word  (word_idx),
        .wr_data  (bus_wdata),
        .cfg      (cfg)
    );

    pinbank_sync #(
        .WIDTH    (NUM_PINS),
        .STAGES   (2)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    pinbank_readback #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W)
    ) u_rdbk (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (bus_rd_en),
        .rd_word  (word_idx),
        .cfg      (cfg),
        .pad_sync (pad_sync),
        .rdata    (bus_rdata)
    );

    pinbank_pad_drive #(
        .NUM_BANKS     (NUM_BANKS),
        .PINS_PER_BANK (PINS_PER_BANK)
    ) u_pads (
        .cfg           (cfg),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .pin_func      (pin_func),
        .pin_pull_up   (pin_pull_up),
        .pin_pull_dn   (pin_pull_dn),
        .pin_drive     (pin_drive)
    );

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr_en,
    input  logic                        bus_rd_en,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]         pin_out,
    input  logic [NUM_PINS-1:0]         pin_oe,
    input  logic [NUM_PINS*FSEL_W-1:0]  pin_func,
    input  logic [NUM_PINS-1:0]         pin_pull_up,
    input  logic [NUM_PINS-1:0]         pin_pull_dn,
    input  logic [NUM_PINS*DRV_W-1:0]   pin_drive
);

    localparam int WORD_W    = ADDR_W - 2;
    localparam int DATA_LO   = data_base(NUM_PINS);
    localparam int DATA_HI   = DATA_LO + data_words(NUM_PINS) - 1;
    localparam int TOTAL     = total_words(NUM_PINS);

    logic [WORD_W-1:0]   widx;
    logic                off_map_wr;
    logic                data_wr;
    logic [NUM_PINS-1:0] oe_from_func;
    logic                rst_d;

    assign widx       = WORD_W'(bus_addr >> 2);
    assign off_map_wr = bus_wr_en && (32'(widx) >= 32'(TOTAL));
    assign data_wr    = bus_wr_en && (32'(widx) >= 32'(DATA_LO)) && (32'(widx) <= 32'(DATA_HI));

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            oe_from_func[p] = (pin_func[p*FSEL_W +: FSEL_W] == FSEL_W'(1));
        end
    end

    always_ff @(posedge clk) rst_d <= rst;

    // R1: one edge after reset is seen, the pads show the reset settings.
    always @(negedge clk) begin
        if (rst_d == 1'b1) begin
            p_reset_r1: assert (pin_oe == '0 && pin_out == '0 && pin_func == '0 &&
                                pin_pull_up == '0 && pin_pull_dn == '0 &&
                                pin_drive == {NUM_PINS{2'b01}})
                else $error("reset pad state wrong");
        end
    end

    p_oe_func_r3: assert property (@(posedge clk) disable iff (rst)
        pin_oe == oe_from_func)
        else $error("output enable does not follow function code");

    p_pull_excl_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_pull_up & pin_pull_dn) == '0)
        else $error("pull-up and pull-down both on");

    p_out_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !data_wr |=> $stable(pin_out))
        else $error("output level changed without a data write");

    p_off_map_r8: assert property (@(posedge clk) disable iff (rst)
        off_map_wr |=> ($stable(pin_func) && $stable(pin_out) && $stable(pin_drive) &&
                        $stable(pin_pull_up) && $stable(pin_pull_dn)))
        else $error("write to unused address changed a pad output");

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> $stable(bus_rdata))
        else $error("read data changed without a read");

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb_top;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_pull_up, pin_pull_dn;
    logic [NP*3-1:0] pin_func;
    logic [NP*2-1:0] pin_drive;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_on = 0;

    // Reference model state, one integer per pin field.
    int m_fsel [NP];
    int m_pull [NP];
    int m_drv  [NP];
    int m_dout [NP];

    always #4 clk = ~clk;

    pinbank_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func),
        .pin_pull_up(pin_pull_up), .pin_pull_dn(pin_pull_dn), .pin_drive(pin_drive)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_fsel[p] = 0; m_pull[p] = 0; m_drv[p] = 1; m_dout[p] = 0;
        end
    endtask

    // Map: words 0-3 function (4-bit slots), 4 data, 5-6 drive, 7-8 pull.
    task automatic model_write(input int w, input logic [31:0] d);
        if (w < 4) begin
            for (int i = 0; i < 8; i++) m_fsel[w*8+i] = int'(d[i*4 +: 3]);
        end else if (w == 4) begin
            for (int i = 0; i < NP; i++) m_dout[i] = int'(d[i]);
        end else if (w == 5 || w == 6) begin
            for (int i = 0; i < 16; i++) m_drv[(w-5)*16+i] = int'(d[i*2 +: 2]);
        end else if (w == 7 || w == 8) begin
            for (int i = 0; i < 16; i++) m_pull[(w-7)*16+i] = int'(d[i*2 +: 2]);
        end
    endtask

    function automatic logic [31:0] model_read(input int w);
        logic [31:0] r = '0;
        if (w < 4) begin
            for (int i = 0; i < 8; i++) r[i*4 +: 3] = 3'(m_fsel[w*8+i]);
        end else if (w == 4) begin
            for (int i = 0; i < NP; i++) r[i] = (m_fsel[i] == 1) ? m_dout[i][0] : pad_in[i];
        end else if (w == 5 || w == 6) begin
            for (int i = 0; i < 16; i++) r[i*2 +: 2] = 2'(m_drv[(w-5)*16+i]);
        end else if (w == 7 || w == 8) begin
            for (int i = 0; i < 16; i++) r[i*2 +: 2] = 2'(m_pull[(w-7)*16+i]);
        end
        return r;
    endfunction

    function automatic int ma_to_code(input int ma);
        return ma / 10 - 1;
    endfunction

    // Per-clock comparison of every pad output against the model (R3, R4, R5, R6).
    always @(negedge clk) begin
        if (model_on && !done) begin
            for (int p = 0; p < NP; p++) begin
                if (pin_func[p*3 +: 3] != 3'(m_fsel[p]) || pin_oe[p] != (m_fsel[p] == 1) ||
                    pin_pull_up[p] != (m_pull[p] == 1) || pin_pull_dn[p] != (m_pull[p] == 2) ||
                    pin_drive[p*2 +: 2] != 2'(m_drv[p]) || pin_out[p] != m_dout[p][0]) begin
                    failures++;
                    $display("FAIL R3/R4/R5/R6 pin %0d actual=f%0d oe%0d u%0d d%0d dr%0d o%0d expected=f%0d p%0d dr%0d o%0d",
                             p, pin_func[p*3 +: 3], pin_oe[p], pin_pull_up[p], pin_pull_dn[p],
                             pin_drive[p*2 +: 2], pin_out[p], m_fsel[p], m_pull[p], m_drv[p], m_dout[p]);
                end
            end
            checks++;
        end
    end

    task automatic bus_write(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'(w * 4); bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0;
        model_write(w, d);
    endtask

    task automatic bus_read(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = 8'(w * 4);
        @(posedge clk);
        #1;
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input string req, input int w);
        logic [31:0] exp;
        logic [31:0] got;
        exp = model_read(w);
        bus_read(w, got);
        check(req, 64'(got), 64'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        model_reset();
        idle(4);
        rst = 1'b0;
        model_on = 1;
        idle(1);

        // R1: reset values at the pads and in every register.
        check("R1 oe", 64'(pin_oe), 64'(0));
        check("R1 out", 64'(pin_out), 64'(0));
        check("R1 drive", pin_drive, {32{2'b01}});
        for (int w = 0; w < 9; w++) read_check("R1 reg", w);

        // R2: reserved slot bit dropped, slot order kept.
        bus_write(0, 32'hFEDC_BA98);
        bus_read(0, rd);
        check("R2 fsel word0", 64'(rd), 64'h7654_3210);
        check("R3 pin1 oe", 64'(pin_oe[1]), 64'(1));
        check("R3 pin7 func", 64'(pin_func[21 +: 3]), 64'(7));
        // R11: neighbouring function word untouched.
        read_check("R11 fsel word1", 1);

        // R6: bank of outputs, data written and read back.
        bus_write(1, 32'h1111_1111);
        pad_in = 32'hFFFF_00FF;
        bus_write(4, 32'h0000_A5F0);
        idle(3);
        check("R6 pin_out", 64'(pin_out), 64'h0000_A5F0);
        read_check("R6/R7 data mixed", 4);
        pad_in = 32'h1234_5678;
        idle(3);
        read_check("R7 data pattern2", 4);
        pad_in = 32'hA5A5_0F0F;
        idle(3);
        read_check("R7 data pattern3", 4);

        // R7: synchronizer depth (pin 0 is an input, pad bit 0 currently 1).
        @(posedge clk); #1;
        pad_in[0] = 1'b0;
        bus_read(4, rd);
        check("R7 sync edge1 old", 64'(rd[0]), 64'(1));
        bus_read(4, rd);
        check("R7 sync edge2 old", 64'(rd[0]), 64'(1));
        bus_read(4, rd);
        check("R7 sync edge3 new", 64'(rd[0]), 64'(0));

        // R5: drive codes for 10..40 mA on pins 0..3.
        bus_write(5, {24'h55_5555, 2'(ma_to_code(40)), 2'(ma_to_code(30)),
                      2'(ma_to_code(20)), 2'(ma_to_code(10))});
        check("R5 drive 10mA", 64'(pin_drive[1:0]), 64'(0));
        check("R5 drive 40mA", 64'(pin_drive[7:6]), 64'(3));
        read_check("R5 drive word", 5);
        bus_write(6, 32'hC3C3_C3C3);
        read_check("R5 drive word bank1", 6);

        // R4: pull codes 0..3 repeating, code 3 stored but inert.
        bus_write(7, 32'hE4E4_E4E4);
        check("R4 pin1 up", 64'(pin_pull_up[1]), 64'(1));
        check("R4 pin2 down", 64'(pin_pull_dn[2]), 64'(1));
        check("R4 pin3 none", 64'({pin_pull_up[3], pin_pull_dn[3]}), 64'(0));
        read_check("R4 pull word", 7);
        bus_write(8, 32'h1B1B_1B1B);
        read_check("R4 pull word bank1", 8);

        // R10: bank 1 position 3 is pin 19.
        bus_write(2, 32'h0000_1000);
        check("R10 pin19 oe", 64'(pin_oe), 64'h0008_FF02);
        bus_write(4, 32'h0008_0000);
        check("R10 pin19 out", 64'(pin_out[19]), 64'(1));

        // R8 and R9: off-map accesses, read data held between reads.
        bus_read(0, held);
        bus_write(9, 32'hFFFF_FFFF);
        bus_write(63, 32'hFFFF_FFFF);
        idle(2);
        check("R9 rdata hold", 64'(bus_rdata), 64'(held));
        bus_read(9, rd);
        check("R8 read word9", 64'(rd), 64'(0));
        bus_read(63, rd);
        check("R8 read word63", 64'(rd), 64'(0));
        for (int w = 0; w < 9; w++) read_check("R8/R11 map intact", w);

        // R11: all-ones into bank 1 function word, bank 0 unaffected.
        bus_write(3, 32'hFFFF_FFFF);
        read_check("R11 fsel word0 after word3", 0);
        read_check("R11 fsel word3", 3);
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule